// File: doc/BRIEF.md
# Timed Access Write Protection Unit

This guard protects a small set of control bits that sit elsewhere in a microcontroller register file. It watches every write on the register bus and looks for writes to one dedicated key register. If a first magic byte is followed by a second magic byte before a short deadline expires, the guard raises a single protected-write-enable signal for a fixed number of clock cycles. The protected registers AND this signal with their own write strobes. When the window ends, the bits are locked again.

The guard is write-only. It holds no readable state and does not modify the bus. Key addresses, both magic bytes, the deadline and the window length are parameters. Their defaults are address C7h, first byte AAh, second byte 55h, a deadline of 3 cycles and a window of 3 cycles.

Top module: `ta_write_guard`

## Requirements
- R1: After a reset cycle, `prot_wr_en` is 0 and no first byte is pending. The key register is treated as holding all ones (FFh), which matches neither magic byte.
- R2: A bus write counts only when `wr_en` is 1 in that cycle. A matching address and data with `wr_en` low has no effect.
- R3: A write of 55h to address C7h opens the window if it comes 1, 2 or 3 clock edges after a write of AAh to C7h. A write 4 or more edges after the AAh does not open it.
- R4: `prot_wr_en` is driven from a register. It reads 1 in the cycle that follows the clock edge of the accepted 55h write.
- R5: Once opened, `prot_wr_en` stays at 1 for exactly 3 consecutive cycles and then returns to 0. Bus activity at other addresses neither shortens nor lengthens the window.
- R6: A 55h write to C7h with no AAh pending, or after the deadline, opens no window and leaves nothing pending.
- R7: While an AAh is pending, a write to C7h of any value other than 55h or AAh cancels the pending state. A later 55h then opens no window.
- R8: A new AAh write to C7h restarts the deadline. A 55h that comes within 3 edges of the newest AAh is accepted, even if it comes more than 3 edges after an earlier AAh.
- R9: Writes to any address other than C7h neither advance nor cancel a pending AAh.
- R10: After the window has closed, a lone 55h does not reopen it. Only a fresh AAh followed by a 55h within the deadline does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register-bus write strobe |
| wr_addr | input | ADDR_W (8) | Register-bus write address |
| wr_data | input | DATA_W (8) | Register-bus write data |
| prot_wr_en | output | 1 | Registered enable for writes to protected bits |

## Verification
The bench builds the guard with its default parameters: key address C7h, bytes AAh and 55h, a 3-cycle deadline and a 3-cycle window. These small counts make both edges of the deadline reachable in a few cycles: a second byte on the third edge is accepted and one on the fourth is refused. They also let the test observe the last open cycle and the first closed one within each scenario. The default sizes also bring into reach a restarted deadline, writes to neighbouring addresses (C6h, C8h, C5h) in the middle of a sequence, and sequences with the strobe held low.

// File: rtl/ta_pkg.sv
package ta_pkg;
  // Classification of one bus cycle as seen by the key register
  typedef enum logic [1:0] {
    KEY_IDLE   = 2'd0,  // no write to the key address
    KEY_FIRST  = 2'd1,  // first magic byte written
    KEY_SECOND = 2'd2,  // second magic byte written
    KEY_OTHER  = 2'd3   // any other value written to the key address
  } key_kind_e;
endpackage

// File: rtl/ta_key_decode.sv
module ta_key_decode
  import ta_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hC7,
  parameter logic [DATA_W-1:0] KEY_A    = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_B    = 8'h55
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output key_kind_e         kind
);
  logic hit;

  assign hit = wr_en && (wr_addr == KEY_ADDR);

  always_comb begin
    if (!hit)                   kind = KEY_IDLE;
    else if (wr_data == KEY_A)  kind = KEY_FIRST;
    else if (wr_data == KEY_B)  kind = KEY_SECOND;
    else                        kind = KEY_OTHER;
  end
endmodule

// File: rtl/ta_arm_timer.sv
module ta_arm_timer
  import ta_pkg::*;
#(
  parameter int ARM_CYCLES = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  key_kind_e kind,
  output logic      accept
);
  localparam int CW = $clog2(ARM_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(ARM_CYCLES);

  logic [CW-1:0] age_q;
  logic          armed;

  assign armed  = (age_q != '0);
  assign accept = (kind == KEY_SECOND) && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= '0;
    end else begin
      unique case (kind)
        KEY_FIRST:            age_q <= LOAD;
        KEY_SECOND, KEY_OTHER: age_q <= '0;
        default:              if (armed) age_q <= age_q - 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ta_window_timer.sv
module ta_window_timer #(
  parameter int OPEN_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  output logic open_q
);
  localparam int CW = $clog2(OPEN_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(OPEN_CYCLES);

  logic [CW-1:0] left_q;
  logic [CW-1:0] left_d;

  always_comb begin
    if (accept)              left_d = LOAD;
    else if (left_q != '0)   left_d = left_q - 1'b1;
    else                     left_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      open_q <= 1'b0;
    end else begin
      left_q <= left_d;
      open_q <= (left_d != '0);
    end
  end
endmodule

// File: rtl/ta_write_guard.sv
module ta_write_guard
  import ta_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hC7,
  parameter logic [DATA_W-1:0] KEY_A    = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_B    = 8'h55,
  parameter int          ARM_CYCLES  = 3,
  parameter int          OPEN_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prot_wr_en
);
  key_kind_e kind;
  logic      accept;

  ta_key_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR(KEY_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .kind(kind)
  );

  ta_arm_timer #(.ARM_CYCLES(ARM_CYCLES)) u_arm (
    .clk(clk), .rst(rst), .kind(kind), .accept(accept)
  );

  ta_window_timer #(.OPEN_CYCLES(OPEN_CYCLES)) u_win (
    .clk(clk), .rst(rst), .accept(accept), .open_q(prot_wr_en)
  );
endmodule

// File: rtl/ta_write_guard_chk.sv
module ta_write_guard_chk #(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hC7,
  parameter logic [DATA_W-1:0] KEY_A    = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_B    = 8'h55,
  parameter int          ARM_CYCLES  = 3,
  parameter int          OPEN_CYCLES = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              prot_wr_en
);
  localparam int AW = $clog2(ARM_CYCLES + 1);
  localparam int RW = $clog2(OPEN_CYCLES + 2);

  logic key_hit, key_a_wr, key_b_wr, key_bad_wr;
  assign key_hit    = wr_en && (wr_addr == KEY_ADDR);
  assign key_a_wr   = key_hit && (wr_data == KEY_A);
  assign key_b_wr   = key_hit && (wr_data == KEY_B);
  assign key_bad_wr = key_hit && !key_a_wr && !key_b_wr;

  // Observer: cycles left for the second byte, from the bus alone
  logic [AW-1:0] chk_age;
  logic          chk_armed;
  assign chk_armed = (chk_age != '0);
  always_ff @(posedge clk) begin
    if (rst)            chk_age <= '0;
    else if (key_a_wr)  chk_age <= AW'(ARM_CYCLES);
    else if (key_hit)   chk_age <= '0;
    else if (chk_armed) chk_age <= chk_age - 1'b1;
  end

  // Observer: open cycles seen since the last accepted unlock
  logic [RW-1:0] chk_run;
  logic          rst_seen;
  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst)                         chk_run <= '0;
    else if (key_b_wr && chk_armed)  chk_run <= '0;
    else if (prot_wr_en && chk_run != RW'(OPEN_CYCLES + 1)) chk_run <= chk_run + 1'b1;
    else if (!prot_wr_en)            chk_run <= '0;
  end

  // R1: output low in the cycle after a reset cycle
  always_ff @(posedge clk) begin
    if (rst_seen) a_r1_reset_low: assert (!prot_wr_en);
  end

  a_r4_open_next: assert property (@(posedge clk) disable iff (rst)
    (key_b_wr && chk_armed) |=> prot_wr_en);

  a_r5_max_len: assert property (@(posedge clk) disable iff (rst)
    prot_wr_en |-> (chk_run < RW'(OPEN_CYCLES)));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (prot_wr_en && (chk_run < RW'(OPEN_CYCLES - 1))) |=> prot_wr_en);

  a_r6_rise_only_on_key: assert property (@(posedge clk) disable iff (rst)
    (!prot_wr_en && !key_b_wr) |=> !prot_wr_en);

  a_r7_cancel: assert property (@(posedge clk) disable iff (rst)
    (key_bad_wr && !prot_wr_en) ##1 (key_b_wr && !key_a_wr) |=> !prot_wr_en);
endmodule

bind ta_write_guard ta_write_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
  .KEY_A(KEY_A), .KEY_B(KEY_B),
  .ARM_CYCLES(ARM_CYCLES), .OPEN_CYCLES(OPEN_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .prot_wr_en(prot_wr_en)
);

// File: tb/tb_ta_write_guard.sv
`timescale 1ns/1ps
module tb_ta_write_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       prot_wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ta_write_guard #(
    .ADDR_W(8), .DATA_W(8), .KEY_ADDR(8'hC7), .KEY_A(8'hAA), .KEY_B(8'h55),
    .ARM_CYCLES(3), .OPEN_CYCLES(3)
  ) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prot_wr_en(prot_wr_en)
  );

  task automatic check(input logic exp, input string req, input string what);
    checks++;
    if (prot_wr_en !== exp) begin
      errors++;
      $display("FAIL %s %s: prot_wr_en=%b expected %b", req, what, prot_wr_en, exp);
    end
  endtask

  // One clock edge with the given bus values; returns at the following falling edge
  task automatic step(input logic en, input logic [7:0] a, input logic [7:0] d);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic key(input logic [7:0] d);
    step(1'b1, 8'hC7, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 8'h00);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    check(1'b0, "R1", "after reset");
    key(8'h55);
    check(1'b0, "R1", "55h right after reset");
    idle(4);
  endtask

  task automatic t_basic;
    key(8'hAA);
    check(1'b0, "R3", "after AAh alone");
    key(8'h55);
    check(1'b1, "R4", "cycle after 55h");
    idle(1);
    check(1'b1, "R5", "second open cycle");
    idle(1);
    check(1'b1, "R5", "third open cycle");
    idle(1);
    check(1'b0, "R5", "closed after three cycles");
    idle(3);
  endtask

  task automatic t_deadline;
    key(8'hAA); idle(2); key(8'h55);
    check(1'b1, "R3", "55h on third edge accepted");
    idle(6);
    key(8'hAA); idle(3); key(8'h55);
    check(1'b0, "R6", "55h on fourth edge refused");
    key(8'h55);
    check(1'b0, "R6", "second late 55h");
    idle(3);
  endtask

  task automatic t_cancel;
    key(8'hAA); key(8'h12); key(8'h55);
    check(1'b0, "R7", "other value cancels pending");
    idle(4);
  endtask

  task automatic t_restart;
    key(8'hAA); idle(2); key(8'hAA); idle(2); key(8'h55);
    check(1'b1, "R8", "second AAh restarts deadline");
    idle(6);
  endtask

  task automatic t_other_addr;
    key(8'hAA);
    step(1'b1, 8'hC6, 8'h55);
    check(1'b0, "R9", "55h at other address");
    step(1'b1, 8'hC8, 8'hAA);
    key(8'h55);
    check(1'b1, "R9", "other-address writes keep pending");
    step(1'b1, 8'hC6, 8'h12);
    check(1'b1, "R9", "window survives other write 1");
    step(1'b1, 8'hC5, 8'h55);
    check(1'b1, "R9", "window survives other write 2");
    idle(1);
    check(1'b0, "R5", "window length unchanged by bus traffic");
    idle(3);
  endtask

  task automatic t_expiry;
    key(8'hAA); key(8'h55); idle(3);
    check(1'b0, "R10", "window expired");
    key(8'h55);
    check(1'b0, "R10", "lone 55h after expiry");
    idle(1);
    key(8'hAA); key(8'h55);
    check(1'b1, "R10", "full sequence reopens");
    idle(4);
  endtask

  task automatic t_strobe;
    step(1'b0, 8'hC7, 8'hAA); key(8'h55);
    check(1'b0, "R2", "AAh without strobe ignored");
    key(8'hAA); step(1'b0, 8'hC7, 8'h55);
    check(1'b0, "R2", "55h without strobe ignored");
    key(8'h55);
    check(1'b1, "R2", "strobeless cycle kept pending");
    idle(4);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_deadline();
    t_cancel();
    t_restart();
    t_other_addr();
    t_expiry();
    t_strobe();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: done=0 expected 1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule